// File: doc/BRIEF.md
# Accumulator ALU with Shared Logic/Overflow Flag

This block is the datapath core of an 8-bit accumulator machine that also has a 16-bit word path. It takes an operation code, an accumulator operand, a second operand and an incoming carry. It returns a result and four condition flags: sign, zero, logic/overflow and carry. The byte operations are add, add-with-carry, subtract, subtract-with-borrow, compare, negate, AND, OR and XOR. The word operations are add, add-with-carry, subtract-with-borrow, AND and OR. A word test reduces any nonzero word to the value 1.

The result is computed combinationally from the current inputs. The flags pass through a register that loads only while the flag-write enable is high, so a sequencer outside the block decides which steps change the condition state. One flag bit has two meanings. After arithmetic it reports signed overflow. After a logic operation it reports whether any of the four top result bits is one. Subtraction and compare treat the carry as a borrow.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (byte add) gives A+B and opcode 1 (byte add with carry) gives A+B+cin, both on bits 7:0. Carry (flags bit 0) is the carry out of bit 7. Logic/overflow (flags bit 1) is set when A and B share a sign and the result sign differs from it.
- R2: Opcode 2 (byte subtract) gives A−B, opcode 3 (subtract with borrow) gives A−B−cin, and opcode 5 (negate) gives 0−A. Carry is set when the minuend is below the subtrahend plus borrow. Overflow is set when the operand signs differ and the result sign differs from the minuend's.
- R3: Opcode 4 (compare) returns A[7:0] unchanged as the result. It sets sign (bit 3) and carry together when A<B, sets zero (bit 2) only when A=B, and clears all three when A>B. Logic/overflow gets the overflow of A−B.
- R4: Opcodes 6, 7 and 8 (byte AND, OR, XOR) combine bits 7:0 bitwise. Carry is cleared. Logic/overflow is set when any of result bits 7:4 is one.
- R5: Opcodes 9, 10 and 11 (word add, add with carry, subtract with borrow) work on all 16 bits. Carry and signed overflow are taken at bit 15, and cin is included for opcodes 10 and 11.
- R6: Opcodes 12 and 13 (word AND, OR) combine 16 bits. Carry is cleared. Logic/overflow is set when any of result bits 15:12 is one.
- R7: Opcode 14 (word test) returns 1 when the 16-bit accumulator input is nonzero and 0 otherwise. Zero follows the result, and sign, logic/overflow and carry are cleared.
- R8: For every opcode other than 3 bits of compare, sign is the top bit of the result width (bit 7 for byte operations, bit 15 for word operations). Zero is set when the whole result is zero. Byte operations return zero in result bits 15:8.
- R9: The flags output changes at a rising clock edge only when flag_we_i was high at that edge, and then takes the flags of the operation on the inputs at that edge. Otherwise it holds.
- R10: Opcode 15 is reserved. It returns a zero result and leaves the flags unchanged even when flag_we_i is high.
- R11: Synchronous active-high reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (0..15, see requirements) |
| acc_i | input | 16 | Accumulator operand; byte operations use bits 7:0 |
| opd_i | input | 16 | Second operand; byte operations use bits 7:0 |
| cin_i | input | 1 | Incoming carry or borrow |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 16 | Combinational result |
| flags_o | output | 4 | Registered flags {sign, zero, logic/overflow, carry} |

## Verification
The result is valid in the same cycle the inputs are applied. The flags come from a register, so they are due one rising edge later. The driver applies each operation just after a falling edge, pushes the expected result and the expected post-edge flags, and holds the inputs steady. The monitor pops one item a short delay after the next rising edge, when the held inputs still produce the same result and the new flags have settled. Because both values are compared at that single point, a one-cycle slip in either path is reported.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD8  = 4'd0,
    OP_ADC8  = 4'd1,
    OP_SUB8  = 4'd2,
    OP_SBC8  = 4'd3,
    OP_CP8   = 4'd4,
    OP_NEG8  = 4'd5,
    OP_AND8  = 4'd6,
    OP_OR8   = 4'd7,
    OP_XOR8  = 4'd8,
    OP_ADD16 = 4'd9,
    OP_ADC16 = 4'd10,
    OP_SBC16 = 4'd11,
    OP_AND16 = 4'd12,
    OP_OR16  = 4'd13,
    OP_TST16 = 4'd14,
    OP_RSVD  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

  localparam int FLAG_W  = 4;
  localparam int FLG_C   = 0;
  localparam int FLG_LV  = 1;
  localparam int FLG_Z   = 2;
  localparam int FLG_S   = 3;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cb_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         ov_o
);
  logic [W-1:0] y_eff;
  logic         c_eff;
  logic [W:0]   ext;

  always_comb begin
    y_eff = sub_i ? ~y_i : y_i;
    c_eff = sub_i ? ~cb_i : cb_i;
    ext   = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    sum_o = ext[W-1:0];
    // carry out of an inverted-operand add means "no borrow"
    cy_o  = sub_i ? ~ext[W] : ext[W];
    if (sub_i)
      ov_o = (x_i[W-1] != y_i[W-1]) && (ext[W-1] != x_i[W-1]);
    else
      ov_o = (x_i[W-1] == y_i[W-1]) && (ext[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  bw_sel_e      sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      BW_AND:  res_o = x_i & y_i;
      BW_OR:   res_o = x_i | y_i;
      BW_XOR:  res_o = x_i ^ y_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] d_i,
  output logic [FW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)
      q_o <= '0;
    else if (load_i)
      q_o <= d_i;
  end

  // R9: a load captures exactly the presented flag vector
  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(d_i)));

  // R11: reset leaves the register clear
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (q_o == '0));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 2 * NARROW_W,
  parameter int LV_SPAN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [WIDE_W-1:0] acc_i,
  input  logic [WIDE_W-1:0] opd_i,
  input  logic              cin_i,
  input  logic              flag_we_i,
  output logic [WIDE_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int PAD_W = WIDE_W - NARROW_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // byte lane operand steering
  logic [NARROW_W-1:0] n_x, n_y, n_sum;
  logic                n_sub, n_cb, n_cy, n_ov;
  // word lane operand steering
  logic                w_sub, w_cb, w_cy, w_ov;
  logic [WIDE_W-1:0]   w_sum;
  bw_sel_e             bw_sel;
  logic [WIDE_W-1:0]   bw_res;

  always_comb begin
    n_x   = (op == OP_NEG8) ? '0 : acc_i[NARROW_W-1:0];
    n_y   = (op == OP_NEG8) ? acc_i[NARROW_W-1:0] : opd_i[NARROW_W-1:0];
    n_sub = (op == OP_SUB8) || (op == OP_SBC8) || (op == OP_CP8) || (op == OP_NEG8);
    n_cb  = ((op == OP_ADC8) || (op == OP_SBC8)) ? cin_i : 1'b0;
    w_sub = (op == OP_SBC16);
    w_cb  = ((op == OP_ADC16) || (op == OP_SBC16)) ? cin_i : 1'b0;
    unique case (op)
      OP_OR8, OP_OR16: bw_sel = BW_OR;
      OP_XOR8:         bw_sel = BW_XOR;
      default:         bw_sel = BW_AND;
    endcase
  end

  alu_addsub #(.W(NARROW_W)) u_lane_byte (
    .x_i(n_x), .y_i(n_y), .cb_i(n_cb), .sub_i(n_sub),
    .sum_o(n_sum), .cy_o(n_cy), .ov_o(n_ov)
  );

  alu_addsub #(.W(WIDE_W)) u_lane_word (
    .x_i(acc_i), .y_i(opd_i), .cb_i(w_cb), .sub_i(w_sub),
    .sum_o(w_sum), .cy_o(w_cy), .ov_o(w_ov)
  );

  alu_bitwise #(.W(WIDE_W)) u_bitwise (
    .x_i(acc_i), .y_i(opd_i), .sel_i(bw_sel), .res_o(bw_res)
  );

  // result and next-flag selection
  logic [WIDE_W-1:0] res;
  logic              f_s, f_z, f_lv, f_c, upd;

  always_comb begin
    res  = '0;
    f_s  = 1'b0;
    f_z  = 1'b0;
    f_lv = 1'b0;
    f_c  = 1'b0;
    upd  = 1'b1;
    unique case (op)
      OP_ADD8, OP_ADC8, OP_SUB8, OP_SBC8, OP_NEG8: begin
        res  = {{PAD_W{1'b0}}, n_sum};
        f_s  = n_sum[NARROW_W-1];
        f_z  = (n_sum == '0);
        f_lv = n_ov;
        f_c  = n_cy;
      end
      OP_CP8: begin
        res  = {{PAD_W{1'b0}}, acc_i[NARROW_W-1:0]};
        f_s  = n_cy;
        f_z  = (n_sum == '0);
        f_lv = n_ov;
        f_c  = n_cy;
      end
      OP_AND8, OP_OR8, OP_XOR8: begin
        res  = {{PAD_W{1'b0}}, bw_res[NARROW_W-1:0]};
        f_s  = bw_res[NARROW_W-1];
        f_z  = (bw_res[NARROW_W-1:0] == '0);
        f_lv = |bw_res[NARROW_W-1 -: LV_SPAN];
      end
      OP_ADD16, OP_ADC16, OP_SBC16: begin
        res  = w_sum;
        f_s  = w_sum[WIDE_W-1];
        f_z  = (w_sum == '0);
        f_lv = w_ov;
        f_c  = w_cy;
      end
      OP_AND16, OP_OR16: begin
        res  = bw_res;
        f_s  = bw_res[WIDE_W-1];
        f_z  = (bw_res == '0);
        f_lv = |bw_res[WIDE_W-1 -: LV_SPAN];
      end
      OP_TST16: begin
        res  = {{(WIDE_W-1){1'b0}}, |acc_i};
        f_z  = ~|acc_i;
      end
      default: upd = 1'b0;
    endcase
  end

  logic [FLAG_W-1:0] flag_next;
  assign flag_next = {f_s, f_z, f_lv, f_c};
  assign result_o  = res;

  alu_flag_reg #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .load_i(flag_we_i & upd),
    .d_i(flag_next), .q_o(flags_o)
  );

  // R9: no enable, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  // R10: reserved code never disturbs the flags
  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd15) |=> $stable(flags_o));

  // R1: byte add overflow agrees with operand signs and the stored sign
  assert_add_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 4'd0) |=>
      (flags_o[FLG_LV] == (($past(acc_i[NARROW_W-1]) == $past(opd_i[NARROW_W-1])) &&
                           (flags_o[FLG_S] != $past(acc_i[NARROW_W-1])))));

  // R3: equal compare sets zero and clears carry
  assert_cp_equal_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 4'd4 && acc_i[NARROW_W-1:0] == opd_i[NARROW_W-1:0]) |=>
      (flags_o[FLG_Z] && !flags_o[FLG_C]));

  // R4 / R6: logic operations leave carry clear
  assert_logic_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && (op_i inside {4'd6, 4'd7, 4'd8, 4'd12, 4'd13})) |=>
      !flags_o[FLG_C]);

  // R7: word test yields only 0 or 1
  assert_test_range_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd14) |-> (result_o[WIDE_W-1:1] == '0));

  // R8: byte operations keep the upper byte clear
  assert_byte_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i <= 4'd8) |-> (result_o[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] acc_i = '0;
  logic [15:0] opd_i = '0;
  logic        cin_i = 1'b0;
  logic        flag_we_i = 1'b0;
  logic [15:0] result_o;
  logic [3:0]  flags_o;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
    .cin_i(cin_i), .flag_we_i(flag_we_i), .result_o(result_o), .flags_o(flags_o)
  );

  typedef struct {
    logic [15:0] res;
    logic [3:0]  flg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int bad = 0;
  logic [3:0] mflags = 4'h0;
  bit finished = 0;

  // expected value model from the requirements: flags {S,Z,LV,C}
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic ci, output logic [15:0] r, output logic [3:0] f,
                       output bit upd);
    logic [8:0]  s9;
    logic [16:0] s17;
    logic [7:0]  x, y, r8;
    logic        s, z, lv, c;
    upd = 1; r = '0; s = 0; z = 0; lv = 0; c = 0;
    case (op)
      4'd0, 4'd1: begin
        s9 = {1'b0, a[7:0]} + {1'b0, b[7:0]} + ((op == 4'd1) ? {8'd0, ci} : 9'd0);
        r8 = s9[7:0]; r = {8'd0, r8}; c = s9[8];
        lv = (a[7] == b[7]) && (r8[7] != a[7]); s = r8[7]; z = (r8 == 0);
      end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        x = (op == 4'd5) ? 8'd0 : a[7:0];
        y = (op == 4'd5) ? a[7:0] : b[7:0];
        s9 = {1'b0, x} - {1'b0, y} - ((op == 4'd3) ? {8'd0, ci} : 9'd0);
        r8 = s9[7:0]; c = s9[8];
        lv = (x[7] != y[7]) && (r8[7] != x[7]); z = (r8 == 0);
        if (op == 4'd4) begin r = {8'd0, a[7:0]}; s = c; end
        else begin r = {8'd0, r8}; s = r8[7]; end
      end
      4'd6, 4'd7, 4'd8: begin
        r8 = (op == 4'd6) ? (a[7:0] & b[7:0]) : (op == 4'd7) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
        r = {8'd0, r8}; s = r8[7]; z = (r8 == 0); lv = |r8[7:4];
      end
      4'd9, 4'd10: begin
        s17 = {1'b0, a} + {1'b0, b} + ((op == 4'd10) ? {16'd0, ci} : 17'd0);
        r = s17[15:0]; c = s17[16];
        lv = (a[15] == b[15]) && (r[15] != a[15]); s = r[15]; z = (r == 0);
      end
      4'd11: begin
        s17 = {1'b0, a} - {1'b0, b} - {16'd0, ci};
        r = s17[15:0]; c = s17[16];
        lv = (a[15] != b[15]) && (r[15] != a[15]); s = r[15]; z = (r == 0);
      end
      4'd12, 4'd13: begin
        r = (op == 4'd12) ? (a & b) : (a | b);
        s = r[15]; z = (r == 0); lv = |r[15:12];
      end
      4'd14: begin r = (a != 0) ? 16'd1 : 16'd0; z = (a == 0); end
      default: upd = 0;
    endcase
    f = {s, z, lv, c};
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:             return "R1 R8";
      4'd2, 4'd3, 4'd5:       return "R2 R8";
      4'd4:                   return "R3";
      4'd6, 4'd7, 4'd8:       return "R4 R8";
      4'd9, 4'd10, 4'd11:     return "R5 R8";
      4'd12, 4'd13:           return "R6 R8";
      4'd14:                  return "R7";
      default:                return "R10";
    endcase
  endfunction

  // driver: apply after a falling edge, push the expectation
  task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic we, input string tag);
    logic [15:0] r;
    logic [3:0]  f;
    bit          upd;
    exp_t        e;
    @(negedge clk);
    op_i = op; acc_i = a; opd_i = b; cin_i = ci; flag_we_i = we;
    model(op, a, b, ci, r, f, upd);
    if (we && upd) mflags = f;
    e.res = r; e.flg = mflags; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one item per rising edge, sampled 1 ns later
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result_o !== e.res || flags_o !== e.flg) begin
        bad++;
        $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                 e.tag, result_o, flags_o, e.res, e.flg);
      end
    end
  end

  task automatic check_flags_clear(input string tag);
    checks++;
    if (flags_o !== 4'h0) begin
      bad++;
      $display("FAIL %s: flags=%b expected flags=0000", tag, flags_o);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1 check_flags_clear("R11 reset");
    @(negedge clk); rst = 1'b0;

    // R1
    drive(4'd0, 16'h007F, 16'h0001, 1'b0, 1'b1, "R1 add overflow");
    drive(4'd0, 16'h00FF, 16'h0001, 1'b0, 1'b1, "R1 R8 add carry zero");
    drive(4'd1, 16'h0010, 16'h0020, 1'b1, 1'b1, "R1 adc cin");
    drive(4'd0, 16'hAB80, 16'h5580, 1'b0, 1'b1, "R1 R8 upper ignored");
    // R2
    drive(4'd2, 16'h0005, 16'h0007, 1'b0, 1'b1, "R2 sub borrow");
    drive(4'd3, 16'h0080, 16'h0000, 1'b1, 1'b1, "R2 sbc overflow");
    drive(4'd5, 16'h0000, 16'h0000, 1'b0, 1'b1, "R2 neg zero");
    drive(4'd5, 16'h0080, 16'h0000, 1'b0, 1'b1, "R2 neg min");
    // R3
    drive(4'd4, 16'h0001, 16'h0080, 1'b0, 1'b1, "R3 cp less");
    drive(4'd4, 16'h0042, 16'h0042, 1'b0, 1'b1, "R3 cp equal");
    drive(4'd4, 16'h0080, 16'h0001, 1'b0, 1'b1, "R3 cp greater");
    // R4
    drive(4'd6, 16'h00BC, 16'h00D5, 1'b1, 1'b1, "R4 and");
    drive(4'd7, 16'h0004, 16'h0001, 1'b0, 1'b1, "R4 or low nibble");
    drive(4'd8, 16'h0053, 16'h0095, 1'b0, 1'b1, "R4 xor");
    // R5
    drive(4'd9, 16'h7FFF, 16'h0001, 1'b0, 1'b1, "R5 add16 overflow");
    drive(4'd10, 16'hFFFF, 16'h0000, 1'b1, 1'b1, "R5 adc16 wrap");
    drive(4'd11, 16'h1000, 16'h1000, 1'b1, 1'b1, "R5 sbc16 borrow");
    // R6
    drive(4'd12, 16'hF0F0, 16'h0FFF, 1'b0, 1'b1, "R6 and16 lv clear");
    drive(4'd13, 16'h1000, 16'h0001, 1'b0, 1'b1, "R6 or16 lv set");
    // R7
    drive(4'd14, 16'h8000, 16'h0000, 1'b0, 1'b1, "R7 test nonzero");
    drive(4'd14, 16'h0000, 16'hFFFF, 1'b0, 1'b1, "R7 test zero");
    // R9 hold then R10 reserved
    drive(4'd0, 16'h00FF, 16'h00FF, 1'b0, 1'b1, "R9 set flags");
    drive(4'd2, 16'h0001, 16'h0001, 1'b0, 1'b0, "R9 hold without enable");
    drive(4'd15, 16'h1234, 16'h5678, 1'b1, 1'b1, "R10 reserved");

    lf = 32'h1D2C3B4A;
    for (int i = 0; i < 300; i++) begin
      logic [3:0] rop;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      rop = lf[3:0];
      drive(rop, lf[19:4], {lf[11:4], lf[31:24]}, lf[20], lf[21] | lf[22], tag_of(rop));
    end

    // R11 mid-run reset after flags were loaded
    drive(4'd2, 16'h0000, 16'h0001, 1'b0, 1'b1, "R2 pre-reset load");
    @(negedge clk); flag_we_i = 1'b0; rst = 1'b1;
    @(posedge clk); #1 check_flags_clear("R11 mid-run reset");
    @(negedge clk); rst = 1'b0; mflags = 4'h0;

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule